// File: doc/BRIEF.md
# MII PHY-side status and isolation

This block is the PHY-side edge of a 10/100 Media Independent Interface. It produces the nibble clock toward the MAC or repeater from a faster reference clock. On every rising edge of that clock it passes transmit nibbles, with their enable and error flags, to the internal line-side transmitter. On the same edges it passes receive nibbles, with their valid and error flags, from the internal line-side receiver onto the MII receive outputs. From the transmit and receive activity it builds the carrier sense and collision indications, and these follow the selected duplex mode.

The block can be connected while the MAC is already powered. After reset it keeps every MII output and the line transmitter disabled, with zeros on the pins, for a programmable number of reference cycles. Both output-enable signals rise together once that count expires. A new duplex setting is adopted only at a nibble edge where both directions are idle, so carrier sense and collision never change meaning in the middle of a frame.

Top module: `mii_phy_side`

## Requirements
- R1: While `rst_n` is low, and until `RELEASE_CYCLES` rising edges of `clk` have passed after it goes high, `mii_oe` and `line_tx_oe` are 0 and every MII output, the nibble clocks and every line transmit output are 0. On the edge that completes the count both enables become 1, and they stay 1.
- R2: `mii_tx_clk` and `mii_rx_clk` are identical. Their period is 2*`HALF_100` reference cycles when `speed_100`=1 and 2*`HALF_10` when `speed_100`=0.
- R3: At each rising nibble-clock edge, `line_tx_en` takes `mii_tx_en`, and `line_txd` takes `mii_txd` if `mii_tx_en`=1 or 4'h0 if it is 0. The values hold until the next rising edge.
- R4: `line_tx_er` is the `mii_tx_er` sampled at that edge ANDed with `mii_tx_en`, so an error flag without an enable never reaches the line.
- R5: At each rising nibble edge, `mii_rx_dv` and `mii_rx_er` take `line_rx_dv` and `line_rx_er`. `mii_rxd` takes `line_rxd` when valid is 1, the false-carrier code 4'hE when valid is 0 and error is 1, and 4'h0 when both are 0.
- R6: In half duplex, `mii_crs` after an edge equals `mii_tx_en` OR `line_rx_dv` sampled at that edge.
- R7: In half duplex, `mii_col` after an edge equals `mii_tx_en` AND `line_rx_dv` sampled at that edge.
- R8: In full duplex (`full_duplex`=1), `mii_crs` follows `line_rx_dv` only, and `mii_col` stays 0.
- R9: The `full_duplex` input is adopted only at a nibble edge where `mii_tx_en` and `line_rx_dv` are both 0. That edge still uses the previous mode, and later edges use the new one. While isolated, the input is adopted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1 selects 100 Mb/s nibble rate, 0 selects 10 Mb/s |
| full_duplex | input | 1 | Requested duplex mode, 1 = full |
| mii_txd | input | 4 | Transmit nibble from the MAC |
| mii_tx_en | input | 1 | Transmit enable from the MAC |
| mii_tx_er | input | 1 | Transmit error from the MAC |
| mii_tx_clk | output | 1 | Transmit nibble clock toward the MAC |
| mii_rx_clk | output | 1 | Receive nibble clock toward the MAC |
| mii_rxd | output | 4 | Receive nibble toward the MAC |
| mii_rx_dv | output | 1 | Receive data valid toward the MAC |
| mii_rx_er | output | 1 | Receive error toward the MAC |
| mii_crs | output | 1 | Carrier sense |
| mii_col | output | 1 | Collision |
| mii_oe | output | 1 | Output enable for all MII outputs |
| line_txd | output | 4 | Nibble to the line transmitter |
| line_tx_en | output | 1 | Enable to the line transmitter |
| line_tx_er | output | 1 | Error to the line transmitter |
| line_tx_oe | output | 1 | Output enable for the line transmitter |
| line_rxd | input | 4 | Nibble from the line receiver |
| line_rx_dv | input | 1 | Valid from the line receiver |
| line_rx_er | input | 1 | Error from the line receiver |

## Verification
During isolation the bench holds both directions active and checks the enables one cycle before the release count ends and again on the edge that ends it. A design that released early, or let activity leak onto the pins, fails there. Carrier sense and collision are checked for every combination of duplex, transmit activity and receive activity, so a swapped full/half formula or a collision in full duplex shows up. The bench also flips the duplex input in the middle of a frame; a design that adopted the new mode at once would drop the collision too early. The receive checks cover an error with no valid flag, which must give the false-carrier nibble, and the transmit checks cover an error with no enable, which must never reach the line. Both nibble clock periods are measured.

// File: rtl/mii_phy_side.sv
module mii_phy_side #(
  parameter int HALF_100       = 1,
  parameter int HALF_10        = 5,
  parameter int RELEASE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100,
  input  logic       full_duplex,
  input  logic [3:0] mii_txd,
  input  logic       mii_tx_en,
  input  logic       mii_tx_er,
  output logic       mii_tx_clk,
  output logic       mii_rx_clk,
  output logic [3:0] mii_rxd,
  output logic       mii_rx_dv,
  output logic       mii_rx_er,
  output logic       mii_crs,
  output logic       mii_col,
  output logic       mii_oe,
  output logic [3:0] line_txd,
  output logic       line_tx_en,
  output logic       line_tx_er,
  output logic       line_tx_oe,
  input  logic [3:0] line_rxd,
  input  logic       line_rx_dv,
  input  logic       line_rx_er
);
  localparam int DIVW = $clog2(HALF_10 + HALF_100 + 1);
  localparam int RELW = $clog2(RELEASE_CYCLES + 1);
  localparam logic [3:0] FALSE_CARRIER = 4'hE;

  logic [RELW-1:0] rel_cnt;
  logic            released;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rel_cnt  <= '0;
      released <= 1'b0;
    end else if (!released) begin
      if (rel_cnt == RELW'(RELEASE_CYCLES - 1)) released <= 1'b1;
      rel_cnt <= rel_cnt + 1'b1;
    end

  logic [DIVW-1:0] div_cnt;
  logic [DIVW-1:0] half_m1;
  logic            nclk;
  logic            wrap;
  logic            nib_stb;

  assign half_m1 = speed_100 ? DIVW'(HALF_100 - 1) : DIVW'(HALF_10 - 1);
  assign wrap    = div_cnt >= half_m1;
  assign nib_stb = released & wrap & ~nclk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      nclk    <= 1'b0;
    end else if (!released) begin
      div_cnt <= '0;
      nclk    <= 1'b0;
    end else if (wrap) begin
      div_cnt <= '0;
      nclk    <= ~nclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end

  logic       dup_q;
  logic [3:0] ltxd_q, rxd_q;
  logic       ltxen_q, ltxer_q, rxdv_q, rxer_q, crs_q, col_q;
  logic       idle_now;

  assign idle_now = ~mii_tx_en & ~line_rx_dv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dup_q   <= 1'b0;
      ltxd_q  <= '0;
      ltxen_q <= 1'b0;
      ltxer_q <= 1'b0;
      rxd_q   <= '0;
      rxdv_q  <= 1'b0;
      rxer_q  <= 1'b0;
      crs_q   <= 1'b0;
      col_q   <= 1'b0;
    end else if (!released) begin
      dup_q <= full_duplex;
    end else if (nib_stb) begin
      ltxd_q  <= mii_tx_en ? mii_txd : 4'h0;
      ltxen_q <= mii_tx_en;
      ltxer_q <= mii_tx_en & mii_tx_er;
      rxdv_q  <= line_rx_dv;
      rxer_q  <= line_rx_er;
      if (line_rx_dv)      rxd_q <= line_rxd;
      else if (line_rx_er) rxd_q <= FALSE_CARRIER;
      else                 rxd_q <= 4'h0;
      crs_q <= line_rx_dv | (mii_tx_en & ~dup_q);
      col_q <= line_rx_dv & mii_tx_en & ~dup_q;
      if (idle_now) dup_q <= full_duplex;
    end

  assign mii_oe     = released;
  assign line_tx_oe = released;
  assign mii_tx_clk = nclk & released;
  assign mii_rx_clk = nclk & released;
  assign mii_rxd    = released ? rxd_q : 4'h0;
  assign mii_rx_dv  = released & rxdv_q;
  assign mii_rx_er  = released & rxer_q;
  assign mii_crs    = released & crs_q;
  assign mii_col    = released & col_q;
  assign line_txd   = released ? ltxd_q : 4'h0;
  assign line_tx_en = released & ltxen_q;
  assign line_tx_er = released & ltxer_q;
endmodule

module mii_phy_side_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mii_oe,
  input logic       line_tx_oe,
  input logic       mii_tx_clk,
  input logic       mii_rx_clk,
  input logic [3:0] mii_rxd,
  input logic       mii_rx_dv,
  input logic       mii_rx_er,
  input logic       mii_crs,
  input logic       mii_col,
  input logic       line_tx_en,
  input logic       line_tx_er,
  input logic       dup
);
  AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mii_oe |-> (!mii_crs && !mii_col && !mii_rx_dv && !line_tx_en && !mii_tx_clk)); // R1
  AST_OE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    mii_oe == line_tx_oe); // R1
  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mii_oe |=> mii_oe); // R1
  AST_CLK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mii_tx_clk == mii_rx_clk); // R2
  AST_TXER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    line_tx_er |-> line_tx_en); // R4
  AST_RXD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mii_rx_dv && !mii_rx_er) |-> (mii_rxd == 4'h0)); // R5
  AST_COL_HAS_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    mii_col |-> mii_crs); // R7
  AST_FULL_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (dup && $stable(dup)) |-> !mii_col); // R8
endmodule

bind mii_phy_side mii_phy_side_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mii_oe(mii_oe), .line_tx_oe(line_tx_oe),
  .mii_tx_clk(mii_tx_clk), .mii_rx_clk(mii_rx_clk), .mii_rxd(mii_rxd),
  .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er), .mii_crs(mii_crs),
  .mii_col(mii_col), .line_tx_en(line_tx_en), .line_tx_er(line_tx_er),
  .dup(dup_q)
);

// File: tb/sim_mii_phy_side.sv
module sim_mii_phy_side;
  localparam int CLK_PERIOD = 10;
  localparam int REL = 64;
  localparam int H100 = 1;
  localparam int H10 = 5;

  logic clk = 0, rst_n = 0, speed_100 = 1, full_duplex = 0;
  logic [3:0] mii_txd = 0, line_rxd = 0;
  logic mii_tx_en = 0, mii_tx_er = 0, line_rx_dv = 0, line_rx_er = 0;
  logic mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er, mii_crs, mii_col, mii_oe;
  logic line_tx_en, line_tx_er, line_tx_oe;
  logic [3:0] mii_rxd, line_txd;

  int checks = 0, fails = 0;
  bit bmode = 0;
  logic [13:0] q_exp[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mii_phy_side #(.HALF_100(H100), .HALF_10(H10), .RELEASE_CYCLES(REL)) u0 (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .full_duplex(full_duplex),
    .mii_txd(mii_txd), .mii_tx_en(mii_tx_en), .mii_tx_er(mii_tx_er),
    .mii_tx_clk(mii_tx_clk), .mii_rx_clk(mii_rx_clk), .mii_rxd(mii_rxd),
    .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er), .mii_crs(mii_crs), .mii_col(mii_col),
    .mii_oe(mii_oe), .line_txd(line_txd), .line_tx_en(line_tx_en),
    .line_tx_er(line_tx_er), .line_tx_oe(line_tx_oe), .line_rxd(line_rxd),
    .line_rx_dv(line_rx_dv), .line_rx_er(line_rx_er));

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic drive(input string tag, input bit fd, input bit ten, input bit ter,
                       input logic [3:0] td, input bit rdv, input bit rer,
                       input logic [3:0] rd);
    logic [3:0] erxd;
    bit crs, col;
    full_duplex = fd; mii_tx_en = ten; mii_tx_er = ter; mii_txd = td;
    line_rx_dv = rdv; line_rx_er = rer; line_rxd = rd;
    erxd = rdv ? rd : (rer ? 4'hE : 4'h0);
    crs = bmode ? rdv : (ten | rdv);
    col = !bmode & ten & rdv;
    q_exp.push_back({erxd, rdv, rer, crs, col, ten ? td : 4'h0, ten, ten & ter});
    q_tag.push_back(tag);
    if (!ten && !rdv) bmode = fd;
    @(posedge mii_tx_clk);
    #2;
  endtask

  always begin
    @(posedge mii_tx_clk);
    #1;
    if (q_exp.size() > 0) begin
      logic [13:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check({mii_rxd, mii_rx_dv, mii_rx_er, mii_crs, mii_col, line_txd, line_tx_en,
             line_tx_er} == e, t,
            int'({mii_rxd, mii_rx_dv, mii_rx_er, mii_crs, mii_col, line_txd,
                  line_tx_en, line_tx_er}), int'(e));
    end
  end

  task automatic period(input int exp_cycles);
    time t0;
    repeat (2) @(posedge mii_tx_clk);
    t0 = $time;
    @(posedge mii_tx_clk);
    check(($time - t0) / CLK_PERIOD == exp_cycles, "R2 nibble period",
          int'(($time - t0) / CLK_PERIOD), exp_cycles);
    #2;
  endtask

  task automatic iso_check(input string tag, input bit exp_on);
    check(mii_oe == exp_on && line_tx_oe == exp_on, tag, {mii_oe, line_tx_oe},
          {exp_on, exp_on});
    if (!exp_on)
      check({mii_crs, mii_col, mii_rx_dv, mii_rxd, line_tx_en, line_txd, mii_tx_clk} == 0,
            "R1 quiet outputs", {mii_crs, mii_col, mii_rx_dv, mii_rxd, line_tx_en,
            line_txd, mii_tx_clk}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    mii_tx_en = 1; mii_txd = 4'h9; line_rx_dv = 1; line_rxd = 4'h5; mii_tx_er = 1;
    repeat (3) @(posedge clk);
    #1 iso_check("R1 in reset", 0);
    @(negedge clk) rst_n = 1;
    repeat (REL - 1) @(posedge clk);
    #1 iso_check("R1 before release", 0);
    @(posedge clk);
    #1 iso_check("R1 at release", 1);
    mii_tx_en = 0; line_rx_dv = 0; mii_tx_er = 0;
    bmode = 0;
    repeat (5) @(posedge clk);
    #1 iso_check("R1 stays released", 1);

    period(2 * H100);
    speed_100 = 0;
    period(2 * H10);
    speed_100 = 1;
    period(2 * H100);

    drive("R3 tx nibble A", 0, 1, 0, 4'hA, 0, 0, 4'h0);
    drive("R3 tx nibble 3", 0, 1, 0, 4'h3, 0, 0, 4'h0);
    drive("R3 tx disabled", 0, 0, 0, 4'hF, 0, 0, 4'h0);
    drive("R4 er no en", 0, 0, 1, 4'h6, 0, 0, 4'h0);
    drive("R4 er with en", 0, 1, 1, 4'h6, 0, 0, 4'h0);
    drive("R5 rx valid", 0, 0, 0, 4'h0, 1, 0, 4'hC);
    drive("R5 rx valid err", 0, 0, 0, 4'h0, 1, 1, 4'h2);
    drive("R5 false carrier", 0, 0, 0, 4'h0, 0, 1, 4'h3);
    drive("R5 rx idle", 0, 0, 0, 4'h0, 0, 0, 4'h7);

    for (int fd = 0; fd < 2; fd++) begin
      drive("R9 idle mode load", fd[0], 0, 0, 4'h0, 0, 0, 4'h0);
      for (int c = 0; c < 4; c++)
        drive(fd ? "R8 full crs col" : "R6 R7 half crs col", fd[0], c[1], 0,
              4'h1, c[0], 0, 4'h4);
    end

    speed_100 = 0;
    drive("R9 idle to half", 0, 0, 0, 4'h0, 0, 0, 4'h0);
    drive("R7 slow collision", 0, 1, 0, 4'h8, 1, 0, 4'h8);
    drive("R9 no switch mid frame", 1, 1, 0, 4'h8, 1, 0, 4'h8);
    drive("R9 still half", 1, 1, 0, 4'h8, 1, 0, 4'h8);
    drive("R9 idle switch", 1, 0, 0, 4'h0, 0, 0, 4'h0);
    drive("R8 now full", 1, 1, 0, 4'h8, 1, 0, 4'h8);
    drive("R8 tx only full", 1, 1, 0, 4'h8, 0, 0, 4'h0);
    drive("R6 idle back half", 0, 0, 0, 4'h0, 0, 0, 4'h0);
    drive("R6 tx only half", 0, 1, 0, 4'h5, 0, 0, 4'h0);

    @(posedge mii_tx_clk);
    #3;
    check(q_exp.size() == 0, "R3 queue drained", q_exp.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule